// File: doc/BRIEF.md
# Prioritized Interrupt Controller with Vector Code

This block gathers interrupt requests from a processor's surroundings and presents them to the core as two request lines and one vector byte. It has three kinds of input. The first is eight active-low external pins, each set to trigger on a falling edge or on a low level. The second is eight active-high internal level lines. The third is a 32-line peripheral interrupt bus, which is folded down onto the eight internal levels. Every source has a bit in a pending register and a bit in a mask register. External pin 0 is non-maskable and drives a separate request line.

The sixteen sources form one fixed priority order. External pins and internal levels alternate in that order: pin 0, level 0, pin 1, level 1, and so on down to level 7. The vector byte is four times the priority index of the winning source. An interrupt handler can therefore add the vector byte to a table base address to find its service routine. For a level-7 request the handler reads the unfolded peripheral word to find the exact peripheral.

Software uses a small register port. A write takes effect on the clock edge where `wr_en` is high. Read data appears on `rd_data` one clock after `addr` is presented. The register addresses are: 0 pending, 1 mask, 2 vector, 3 pin mode, 4 peripheral word, and 5 to 7 read as zero.

Top module: `prio_irq_ctrl`

## Requirements
- R1: Source priority index s runs 0..15, highest first. External pin k has index 2k and internal level k has index 2k+1. `vector` equals 4*s for the highest-priority eligible source (pin 0 gives 0x00, level 0 gives 0x04, level 7 gives 0x3C).
- R2: When no source is eligible, `vector` is 0xFF. Reading address 2 returns the vector in bits 7:0 and zero above.
- R3: The pending word at address 0 is big-endian: source s sits at bit 31-s when bits are numbered from the LSB. Word bits 15:0 are reserved and always read as zero.
- R4: The mask word at address 1 uses the same bit positions as the pending word, and its reset value is 0. A source from 1 to 15 raises `irq_req` and competes for `vector` only when its mask bit is 1.
- R5: Pin 0 ignores its mask bit. While pin 0 is pending, `nmi_req` is 1 and `vector` is 0x00, and pin 0 never raises `irq_req`.
- R6: The mode register at address 3 holds one bit per pin: bit k controls pin k. A value of 1 selects falling-edge trigger and 0 selects low-level trigger. Its reset value is 0.
- R7: In edge mode, a falling edge on the pin sets the pin's pending bit. The bit stays set after the pin returns high. Writing 1 to that bit at address 0 clears it. If a new edge and a clear arrive in the same cycle, the edge wins.
- R8: In level mode, a pin's pending bit follows the inverted pin. Internal level bits follow their input. Writing 1 to these bits has no effect.
- R9: Peripheral lines 0..6 are ORed into internal levels 0..6. Lines 7..31 are all ORed into internal level 7.
- R10: Address 4 returns the sampled peripheral bus, with line j at bit j. A stable input change reaches the pending bits, `irq_req`, `nmi_req` and `vector` within three rising edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ext_irq_n | input | 8 | Active-low external interrupt pins |
| int_lvl | input | 8 | Active-high internal interrupt levels |
| periph_lvl | input | 32 | Peripheral interrupt bus, line j = level j |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register address for read and write |
| wr_data | input | 32 | Register write data |
| rd_data | output | 32 | Registered read data, one cycle after addr |
| irq_req | output | 1 | Maskable request to the core |
| nmi_req | output | 1 | Non-maskable request (pin 0) |
| vector | output | 8 | Vector code of the winning source, 0xFF if none |

## Verification
The bench builds the block with its default parameters: eight pins, eight levels and a 32-line peripheral bus. With these values every one of the sixteen priority slots and every vector code from 0x00 to 0x3C can be reached. All 25 peripheral lines that share level 7 can also be driven. Directed cases cover each source on its own, adjacent pairs for priority, masking, pin 0 bypassing its mask, and edge latching with write-one-to-clear. Random rounds draw level-mode patterns with random masks and compare the outputs against a priority model in the bench.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int WORD_W = 32;
  localparam int VEC_W  = 8;
  typedef enum logic [2:0] {
    A_PEND   = 3'd0,
    A_MASK   = 3'd1,
    A_VEC    = 3'd2,
    A_MODE   = 3'd3,
    A_PERIPH = 3'd4
  } reg_addr_e;
endpackage

// File: rtl/irqc_pin_cond.sv
module irqc_pin_cond #(
  parameter int NPIN = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NPIN-1:0] pin_n,
  input  logic [NPIN-1:0] edge_mode,
  input  logic [NPIN-1:0] clr,
  output logic [NPIN-1:0] pend
);
  logic [NPIN-1:0] samp, samp_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      samp   <= '1;
      samp_d <= '1;
    end else begin
      samp   <= pin_n;
      samp_d <= samp;
    end
  end

  for (genvar k = 0; k < NPIN; k++) begin : g_pin
    always_ff @(posedge clk) begin
      if (rst) pend[k] <= 1'b0;
      else if (edge_mode[k]) begin
        if (samp_d[k] && !samp[k]) pend[k] <= 1'b1;
        else if (clr[k])          pend[k] <= 1'b0;
      end else pend[k] <= ~samp[k];
    end

    // R7: a latched edge survives until cleared or the mode changes
    assert_edge_hold_R7: assert property (@(posedge clk) disable iff (rst)
      (edge_mode[k] && pend[k] && !clr[k]) |=> (pend[k] || !edge_mode[k]));
    // R8: a low sampled pin in level mode is pending on the next edge
    assert_level_follow_R8: assert property (@(posedge clk) disable iff (rst)
      (!edge_mode[k] && !samp[k]) |=> (pend[k] || edge_mode[k]));
  end
endmodule

// File: rtl/irqc_level_fold.sv
module irqc_level_fold #(
  parameter int NLVL = 8,
  parameter int NPER = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NLVL-1:0] int_lvl,
  input  logic [NPER-1:0] periph,
  output logic [NLVL-1:0] lvl_pend,
  output logic [NPER-1:0] periph_q
);
  localparam int TOP = NLVL - 1;
  logic [NLVL-1:0] int_q;
  logic [NLVL-1:0] folded;

  always_ff @(posedge clk) begin
    if (rst) begin
      int_q    <= '0;
      periph_q <= '0;
    end else begin
      int_q    <= int_lvl;
      periph_q <= periph;
    end
  end

  for (genvar k = 0; k < TOP; k++) begin : g_direct
    assign folded[k] = periph_q[k];
  end
  assign folded[TOP] = |periph_q[NPER-1:TOP];

  always_ff @(posedge clk) begin
    if (rst) lvl_pend <= '0;
    else     lvl_pend <= int_q | folded;
  end

  // R9: any shared peripheral line lands on the lowest level
  assert_fold_top_R9: assert property (@(posedge clk) disable iff (rst)
    (|periph_q[NPER-1:TOP]) |=> lvl_pend[TOP]);
endmodule

// File: rtl/irqc_prio_enc.sv
module irqc_prio_enc #(
  parameter int NSRC  = 16,
  parameter int VEC_W = 8
) (
  input  logic [NSRC-1:0]  elig,
  output logic [VEC_W-1:0] code
);
  always_comb begin
    code = '1;
    for (int s = NSRC - 1; s >= 0; s--) begin
      if (elig[s]) code = VEC_W'(s * 4);
    end
  end
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
  import irqc_pkg::*;
#(
  parameter int NPIN = 8,
  parameter int NPER = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NPIN-1:0]   ext_irq_n,
  input  logic [NPIN-1:0]   int_lvl,
  input  logic [NPER-1:0]   periph_lvl,
  input  logic              wr_en,
  input  logic [2:0]        addr,
  input  logic [WORD_W-1:0] wr_data,
  output logic [WORD_W-1:0] rd_data,
  output logic              irq_req,
  output logic              nmi_req,
  output logic [VEC_W-1:0]  vector
);
  localparam int NSRC = 2 * NPIN;

  logic [NPIN-1:0]   pin_mode, pin_clr, pin_pend, lvl_pend;
  logic [NPER-1:0]   periph_q;
  logic [NSRC-1:0]   src_pend, src_mask, elig;
  logic [WORD_W-1:0] pend_word, mask_word;
  logic [VEC_W-1:0]  code;

  for (genvar k = 0; k < NPIN; k++) begin : g_map
    assign src_pend[2*k]   = pin_pend[k];
    assign src_pend[2*k+1] = lvl_pend[k];
    assign pin_clr[k] = wr_en && (addr == A_PEND) && wr_data[WORD_W-1-2*k];
  end

  for (genvar s = 0; s < WORD_W; s++) begin : g_word
    if (s < NSRC) begin : g_used
      assign pend_word[WORD_W-1-s] = src_pend[s];
      assign mask_word[WORD_W-1-s] = src_mask[s];
    end else begin : g_rsvd
      assign pend_word[WORD_W-1-s] = 1'b0;
      assign mask_word[WORD_W-1-s] = 1'b0;
    end
  end

  irqc_pin_cond #(.NPIN(NPIN)) u_pins (
    .clk(clk), .rst(rst), .pin_n(ext_irq_n), .edge_mode(pin_mode),
    .clr(pin_clr), .pend(pin_pend)
  );

  irqc_level_fold #(.NLVL(NPIN), .NPER(NPER)) u_fold (
    .clk(clk), .rst(rst), .int_lvl(int_lvl), .periph(periph_lvl),
    .lvl_pend(lvl_pend), .periph_q(periph_q)
  );

  assign elig = src_pend & {src_mask[NSRC-1:1], 1'b1};

  irqc_prio_enc #(.NSRC(NSRC), .VEC_W(VEC_W)) u_enc (
    .elig(elig), .code(code)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      src_mask <= '0;
      pin_mode <= '0;
    end else if (wr_en) begin
      if (addr == A_MASK)
        for (int s = 0; s < NSRC; s++) src_mask[s] <= wr_data[WORD_W-1-s];
      if (addr == A_MODE) pin_mode <= wr_data[NPIN-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_req <= 1'b0;
      nmi_req <= 1'b0;
      vector  <= '1;
    end else begin
      irq_req <= |elig[NSRC-1:1];
      nmi_req <= src_pend[0];
      vector  <= code;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else begin
      case (addr)
        A_PEND:   rd_data <= pend_word;
        A_MASK:   rd_data <= mask_word;
        A_VEC:    rd_data <= WORD_W'(vector);
        A_MODE:   rd_data <= WORD_W'(pin_mode);
        A_PERIPH: rd_data <= WORD_W'(periph_q);
        default:  rd_data <= '0;
      endcase
    end
  end

  // R2: with no request line active the vector is the idle code
  assert_idle_vec_R2: assert property (@(posedge clk) disable iff (rst)
    (!irq_req && !nmi_req) |-> (vector == 8'hFF));
  // R1: a valid vector is a multiple of four within the source range
  assert_vec_align_R1: assert property (@(posedge clk) disable iff (rst)
    (vector == 8'hFF) || ((vector[1:0] == 2'b00) && (vector <= 8'(4*(NSRC-1)))));
  // R5: the non-maskable pin always wins the vector
  assert_nmi_top_R5: assert property (@(posedge clk) disable iff (rst)
    nmi_req |-> (vector == 8'h00));
  // R3: reserved pending bits read back as zero
  assert_reserved_zero_R3: assert property (@(posedge clk) disable iff (rst)
    ($past(addr) == A_PEND) |-> (rd_data[WORD_W-1-NSRC:0] == '0));
endmodule

// File: tb/tb_prio_irq_ctrl.sv
module tb_prio_irq_ctrl;
  logic        clk = 1'b0;
  logic        rst;
  logic [7:0]  ext_irq_n;
  logic [7:0]  int_lvl;
  logic [31:0] periph_lvl;
  logic        wr_en;
  logic [2:0]  addr;
  logic [31:0] wr_data;
  logic [31:0] rd_data;
  logic        irq_req, nmi_req;
  logic [7:0]  vector;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #10 clk = ~clk;

  prio_irq_ctrl dut (
    .clk(clk), .rst(rst), .ext_irq_n(ext_irq_n), .int_lvl(int_lvl),
    .periph_lvl(periph_lvl), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
    .rd_data(rd_data), .irq_req(irq_req), .nmi_req(nmi_req), .vector(vector)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a;
    @(negedge clk);
    d = rd_data;
  endtask

  function automatic logic [15:0] src_of(input logic [7:0] pins_n, input logic [7:0] lv,
                                          input logic [31:0] per);
    logic [15:0] p;
    for (int k = 0; k < 8; k++) begin
      p[2*k]   = ~pins_n[k];
      p[2*k+1] = lv[k] | ((k < 7) ? per[k] : |per[31:7]);
    end
    return p;
  endfunction

  function automatic logic [31:0] word_of(input logic [15:0] p);
    logic [31:0] w = '0;
    for (int s = 0; s < 16; s++) w[31-s] = p[s];
    return w;
  endfunction

  function automatic logic [7:0] exp_vec(input logic [15:0] p, input logic [15:0] m);
    for (int s = 0; s < 16; s++)
      if (p[s] && (s == 0 || m[s])) return 8'(4 * s);
    return 8'hFF;
  endfunction

  task automatic check_outs(input string req, input logic [15:0] p, input logic [15:0] m);
    chk(req, {24'b0, vector}, {24'b0, exp_vec(p, m)});
    chk(req, {31'b0, irq_req}, {31'b0, |(p[15:1] & m[15:1])});
    chk(req, {31'b0, nmi_req}, {31'b0, p[0]});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    logic [15:0] p, m;
    void'($urandom(32'd1234));
    rst = 1'b1; ext_irq_n = '1; int_lvl = '0; periph_lvl = '0;
    wr_en = 1'b0; addr = '0; wr_data = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // reset state
    check_outs("R2 reset", 16'h0, 16'h0);
    rd(3'd0, d); chk("R3 reset pending", d, 32'h0);
    rd(3'd1, d); chk("R4 reset mask", d, 32'h0);
    rd(3'd3, d); chk("R6 reset mode", d, 32'h0);
    rd(3'd2, d); chk("R2 vector read idle", d, 32'h0000_00FF);

    wr(3'd1, 32'hFFFF_FFFF);
    rd(3'd1, d); chk("R4 mask readback", d, 32'hFFFF_0000);
    m = 16'hFFFF;

    // each source alone
    for (int k = 0; k < 8; k++) begin
      @(negedge clk); int_lvl = 8'(1 << k);
      settle();
      p = src_of(ext_irq_n, int_lvl, periph_lvl);
      check_outs("R1 level alone", p, m);
      rd(3'd0, d); chk("R3 level bit", d, 32'h8000_0000 >> (2*k+1));
      @(negedge clk); int_lvl = '0;
      ext_irq_n = ~(8'(1 << k));
      settle();
      p = src_of(ext_irq_n, int_lvl, periph_lvl);
      check_outs((k == 0) ? "R5 pin0 alone" : "R1 pin alone", p, m);
      rd(3'd2, d); chk("R2 vector read", d, {24'b0, 8'(8 * k)});
      @(negedge clk); ext_irq_n = '1;
    end
    settle();
    check_outs("R2 idle again", 16'h0, m);

    // priority between neighbours
    @(negedge clk); ext_irq_n = 8'b1111_1101; int_lvl = 8'b0000_0001;
    settle();
    check_outs("R1 level0 over pin1", src_of(ext_irq_n, int_lvl, periph_lvl), m);
    chk("R1 vector 0x04", {24'b0, vector}, 32'h04);
    @(negedge clk); ext_irq_n = '1; int_lvl = '0;

    // masking
    wr(3'd1, 32'h0000_0000); m = 16'h0;
    @(negedge clk); int_lvl = 8'b0000_1000;
    settle();
    chk("R4 masked irq", {31'b0, irq_req}, 32'h0);
    chk("R4 masked vector", {24'b0, vector}, 32'hFF);
    @(negedge clk); ext_irq_n = 8'b1111_1110;
    settle();
    chk("R5 pin0 nmi masked", {31'b0, nmi_req}, 32'h1);
    chk("R5 pin0 no irq", {31'b0, irq_req}, 32'h0);
    chk("R5 pin0 vector", {24'b0, vector}, 32'h0);
    @(negedge clk); ext_irq_n = '1; int_lvl = '0;
    wr(3'd1, 32'hFFFF_0000); m = 16'hFFFF;
    settle();

    // edge mode
    wr(3'd3, 32'h0000_00FF);
    rd(3'd3, d); chk("R6 mode readback", d, 32'h0000_00FF);
    @(negedge clk); ext_irq_n = 8'b1111_1011;
    settle();
    @(negedge clk); ext_irq_n = '1;
    settle();
    rd(3'd0, d); chk("R7 edge latched", d, 32'h0800_0000);
    chk("R7 edge vector", {24'b0, vector}, 32'h10);
    wr(3'd0, 32'h0800_0000);
    settle();
    rd(3'd0, d); chk("R7 edge cleared", d, 32'h0);
    chk("R7 cleared vector", {24'b0, vector}, 32'hFF);

    // level mode ignores clear
    wr(3'd3, 32'h0);
    @(negedge clk); ext_irq_n = 8'b1111_0111;
    settle();
    wr(3'd0, 32'hFFFF_FFFF);
    settle();
    rd(3'd0, d); chk("R8 level not cleared", d, 32'h0200_0000);
    @(negedge clk); ext_irq_n = '1;
    settle();

    // peripheral folding
    @(negedge clk); periph_lvl = 32'h0010_0000;
    settle();
    chk("R9 shared line to level7", {24'b0, vector}, 32'h3C);
    rd(3'd4, d); chk("R10 periph word", d, 32'h0010_0000);
    @(negedge clk); periph_lvl = 32'h0000_0008;
    settle();
    chk("R9 direct line 3", {24'b0, vector}, 32'h1C);
    @(negedge clk); periph_lvl = '0;

    // timing: change visible after three edges, not before two
    @(negedge clk); int_lvl = 8'h80;
    @(negedge clk); @(negedge clk);
    chk("R10 not early", {31'b0, irq_req}, 32'h0);
    @(negedge clk);
    chk("R10 three edges", {31'b0, irq_req}, 32'h1);
    @(negedge clk); int_lvl = '0;
    settle();

    // random level-mode rounds
    for (int i = 0; i < 60; i++) begin
      m = 16'($urandom);
      wr(3'd1, {m[0], m[1], m[2], m[3], m[4], m[5], m[6], m[7],
                m[8], m[9], m[10], m[11], m[12], m[13], m[14], m[15], 16'h0});
      @(negedge clk);
      ext_irq_n  = 8'($urandom | $urandom);
      int_lvl    = 8'($urandom & $urandom & $urandom);
      periph_lvl = $urandom & $urandom & $urandom;
      settle();
      p = src_of(ext_irq_n, int_lvl, periph_lvl);
      check_outs("R1 R4 random", p, m);
      rd(3'd0, d); chk("R3 R9 random pending", d, word_of(p));
      rd(3'd4, d); chk("R10 random periph", d, periph_lvl);
    end

    done = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule